// File: doc/BRIEF.md
# Two-Phase Snooping Bus Arbiter

This block decides who owns a shared snooping bus. The bus serves NPROC processor agents, with ids 0 to NPROC-1, and one memory agent whose id is NPROC. Each bus cycle is split into two phases. In the action phase processors issue new commands. In the reaction phase snoopers holding dirty data, or the memory, answer. At the start of every phase the arbiter chooses one requester and publishes four things to all agents: the winner's id, its command, its address and its priority. These stay valid until the next phase begins. The winning agent also receives a grant pulse that lasts one cycle.

The environment marks a phase start with `phase_start` and gives its kind on `phase_sel` (0 = action, 1 = reaction). Every processor presents a command, an address and a high-priority bit in that same cycle. The memory agent's request is not an input. The arbiter raises it itself, in a reaction phase, when the preceding action-phase winner issued a read or a write.

Among normal-priority requests a rotation applies, measured from the last processor that won an action phase. A high-priority request, used for a dirty-data reply, overrides the rotation.

Top module: `bus_arb_top`

## Requirements
- R1: After reset the outputs read as follows: `win_id` is all ones, `win_cmd` is 0, `win_addr` is 0, `win_hi` is 0, `grant` is 0 and `cycle_cnt` is 0.
- R2: Each phase start replaces all winner outputs, one cycle later. If nothing requests, `win_id` reads all ones (no winner) and `win_cmd`, `win_addr` and `win_hi` read 0. Between phase starts the winner outputs do not change.
- R3: `cycle_cnt` goes up by one on each action-phase start and is otherwise unchanged.
- R4: A processor with command 0 (null) does not request, even when its high-priority bit is set.
- R5: A requester with its high-priority bit set beats every normal-priority requester, and `win_hi` shows it. The environment presents at most one such request per phase.
- R6: Among normal-priority processor requests, the winner has the smallest distance (id - (last+1)) mod NPROC, where last is the last-winner pointer.
- R7: The last-winner pointer resets to NPROC-1, so processor 0 wins the first contested action phase after reset.
- R8: The last-winner pointer moves only when a processor wins an action phase. Reaction-phase wins and memory wins leave it unchanged.
- R9: In a reaction phase the memory agent (id NPROC) requests at normal priority, with command 4 (reply) and the action winner's address, when the action winner's command was 1 (read) or 2 (write). Any normal processor request beats it.
- R10: `grant` is one-hot, bit `win_id`, for exactly the one cycle after a phase start that has a winner, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_start | input | 1 | Marks the first cycle of a phase; requests are sampled here |
| phase_sel | input | 1 | Phase kind: 0 action, 1 reaction |
| proc_cmd | input | NPROC*3 | Per-processor command, 3 bits each, processor 0 in the low bits |
| proc_addr | input | NPROC*ADDR_W | Per-processor address |
| proc_hi | input | NPROC | Per-processor high-priority bit |
| win_id | output | clog2(NPROC+2) | Winner id, all ones when none |
| win_cmd | output | 3 | Winner command |
| win_addr | output | ADDR_W | Winner address |
| win_hi | output | 1 | Winner priority |
| grant | output | NPROC+1 | One-cycle grant pulse, bit NPROC is memory |
| cycle_cnt | output | CYC_W | Count of action phases |

## Verification
A bad winner register shows up at the ports one cycle after the phase start that loaded it, and it stays visible for the whole phase. A corrupted last-winner pointer stays hidden until the next action phase in which two or more processors contend. The stimulus therefore follows each reaction phase with a contested action phase whose winner depends on whether the pointer moved. A wrongly latched action command shows up only in the reaction phase that follows, as a missing or spurious memory reply. A counter fault is visible on `cycle_cnt` right after the phase start that caused it.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_WR   = 3'd2,
    CMD_UPG  = 3'd3,
    CMD_RPLY = 3'd4,
    CMD_WB   = 3'd5
  } bus_cmd_e;

  // rotation distance of requester id behind pointer last, modulo n
  function automatic int rr_distance(input int id, input int last, input int n);
    return (id + n - ((last + 1) % n)) % n;
  endfunction

  // commands that need data from memory
  function automatic logic needs_fill(input logic [CMD_W-1:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction
endpackage

// File: rtl/bus_arb_reqmux.sv
module bus_arb_reqmux
  import bus_arb_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  localparam int NAG   = NPROC + 1
) (
  input  logic                             phase_sel,
  input  logic [NPROC-1:0][CMD_W-1:0]      p_cmd,
  input  logic [NPROC-1:0][ADDR_W-1:0]     p_addr,
  input  logic [NPROC-1:0]                 p_hi,
  input  logic [CMD_W-1:0]                 act_cmd,
  input  logic [ADDR_W-1:0]                act_addr,
  output logic                             mem_req,
  output logic [NAG-1:0]                   req_v,
  output logic [NAG-1:0]                   req_hi,
  output logic [NAG-1:0][CMD_W-1:0]        req_cmd,
  output logic [NAG-1:0][ADDR_W-1:0]       req_addr
);
  assign mem_req = phase_sel && needs_fill(act_cmd);

  for (genvar g = 0; g < NPROC; g++) begin : g_proc
    assign req_v[g]    = (p_cmd[g] != CMD_NONE);
    assign req_hi[g]   = req_v[g] && p_hi[g];
    assign req_cmd[g]  = p_cmd[g];
    assign req_addr[g] = p_addr[g];
  end

  assign req_v[NPROC]    = mem_req;
  assign req_hi[NPROC]   = 1'b0;
  assign req_cmd[NPROC]  = CMD_RPLY;
  assign req_addr[NPROC] = act_addr;
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick
  import bus_arb_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  localparam int NAG   = NPROC + 1,
  localparam int ID_W  = $clog2(NPROC + 2),
  localparam int PTR_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NAG-1:0]               req_v,
  input  logic [NAG-1:0]               req_hi,
  input  logic [NAG-1:0][CMD_W-1:0]    req_cmd,
  input  logic [NAG-1:0][ADDR_W-1:0]   req_addr,
  input  logic [PTR_W-1:0]             last_ptr,
  output logic                         sel_valid,
  output logic [ID_W-1:0]              sel_id,
  output logic [CMD_W-1:0]             sel_cmd,
  output logic [ADDR_W-1:0]            sel_addr,
  output logic                         sel_hi
);
  int best_key;
  int sel_idx;
  int key;

  // key 0 for high priority, 1+distance for processors, NPROC+1 for memory
  always_comb begin
    best_key  = 0;
    sel_idx   = 0;
    sel_valid = 1'b0;
    key       = 0;
    for (int i = 0; i < NAG; i++) begin
      if (req_v[i]) begin
        if (req_hi[i])
          key = 0;
        else if (i == NPROC)
          key = NPROC + 1;
        else
          key = 1 + rr_distance(i, int'(last_ptr), NPROC);
        if (!sel_valid || key < best_key) begin
          sel_valid = 1'b1;
          best_key  = key;
          sel_idx   = i;
        end
      end
    end
  end

  assign sel_id   = ID_W'(sel_idx);
  assign sel_cmd  = req_cmd[sel_idx];
  assign sel_addr = req_addr[sel_idx];
  assign sel_hi   = req_hi[sel_idx];
endmodule

// File: rtl/bus_arb_regs.sv
module bus_arb_regs
  import bus_arb_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 32,
  localparam int NAG   = NPROC + 1,
  localparam int ID_W  = $clog2(NPROC + 2),
  localparam int PTR_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phase_start,
  input  logic                 phase_sel,
  input  logic                 sel_valid,
  input  logic [ID_W-1:0]      sel_id,
  input  logic [CMD_W-1:0]     sel_cmd,
  input  logic [ADDR_W-1:0]    sel_addr,
  input  logic                 sel_hi,
  output logic [ID_W-1:0]      win_id,
  output logic [CMD_W-1:0]     win_cmd,
  output logic [ADDR_W-1:0]    win_addr,
  output logic                 win_hi,
  output logic [NAG-1:0]       grant,
  output logic [CYC_W-1:0]     cycle_cnt,
  output logic [PTR_W-1:0]     last_ptr,
  output logic [CMD_W-1:0]     act_cmd,
  output logic [ADDR_W-1:0]    act_addr
);
  logic act_start;
  logic proc_won;

  assign act_start = phase_start && !phase_sel;
  assign proc_won  = sel_valid && (sel_id < ID_W'(NPROC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_id    <= '1;
      win_cmd   <= CMD_NONE;
      win_addr  <= '0;
      win_hi    <= 1'b0;
      grant     <= '0;
      cycle_cnt <= '0;
      last_ptr  <= PTR_W'(NPROC - 1);
      act_cmd   <= CMD_NONE;
      act_addr  <= '0;
    end else begin
      grant <= '0;
      if (phase_start) begin
        if (sel_valid) begin
          win_id   <= sel_id;
          win_cmd  <= sel_cmd;
          win_addr <= sel_addr;
          win_hi   <= sel_hi;
          grant    <= NAG'(1) << sel_id;
        end else begin
          win_id   <= '1;
          win_cmd  <= CMD_NONE;
          win_addr <= '0;
          win_hi   <= 1'b0;
        end
      end
      if (act_start) begin
        cycle_cnt <= cycle_cnt + CYC_W'(1);
        act_cmd   <= sel_valid ? sel_cmd : CMD_NONE;
        act_addr  <= sel_valid ? sel_addr : '0;
        if (proc_won)
          last_ptr <= PTR_W'(sel_id);
      end
    end
  end
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
  import bus_arb_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 32,
  localparam int NAG   = NPROC + 1,
  localparam int ID_W  = $clog2(NPROC + 2),
  localparam int PTR_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      phase_start,
  input  logic                      phase_sel,
  input  logic [NPROC*CMD_W-1:0]    proc_cmd,
  input  logic [NPROC*ADDR_W-1:0]   proc_addr,
  input  logic [NPROC-1:0]          proc_hi,
  output logic [ID_W-1:0]           win_id,
  output logic [CMD_W-1:0]          win_cmd,
  output logic [ADDR_W-1:0]         win_addr,
  output logic                      win_hi,
  output logic [NAG-1:0]            grant,
  output logic [CYC_W-1:0]          cycle_cnt
);
  logic [NPROC-1:0][CMD_W-1:0]   p_cmd;
  logic [NPROC-1:0][ADDR_W-1:0]  p_addr;
  logic [NAG-1:0]                req_v;
  logic [NAG-1:0]                req_hi;
  logic [NAG-1:0][CMD_W-1:0]     req_cmd;
  logic [NAG-1:0][ADDR_W-1:0]    req_addr;
  logic                          mem_req;
  logic                          sel_valid;
  logic [ID_W-1:0]               sel_id;
  logic [CMD_W-1:0]              sel_cmd;
  logic [ADDR_W-1:0]             sel_addr;
  logic                          sel_hi;
  logic [PTR_W-1:0]              last_ptr;
  logic [CMD_W-1:0]              act_cmd;
  logic [ADDR_W-1:0]             act_addr;

  assign p_cmd  = proc_cmd;
  assign p_addr = proc_addr;

  bus_arb_reqmux #(.NPROC(NPROC), .ADDR_W(ADDR_W)) u_reqmux (
    .phase_sel (phase_sel),
    .p_cmd     (p_cmd),
    .p_addr    (p_addr),
    .p_hi      (proc_hi),
    .act_cmd   (act_cmd),
    .act_addr  (act_addr),
    .mem_req   (mem_req),
    .req_v     (req_v),
    .req_hi    (req_hi),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr)
  );

  bus_arb_pick #(.NPROC(NPROC), .ADDR_W(ADDR_W)) u_pick (
    .req_v     (req_v),
    .req_hi    (req_hi),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .last_ptr  (last_ptr),
    .sel_valid (sel_valid),
    .sel_id    (sel_id),
    .sel_cmd   (sel_cmd),
    .sel_addr  (sel_addr),
    .sel_hi    (sel_hi)
  );

  bus_arb_regs #(.NPROC(NPROC), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_start (phase_start),
    .phase_sel   (phase_sel),
    .sel_valid   (sel_valid),
    .sel_id      (sel_id),
    .sel_cmd     (sel_cmd),
    .sel_addr    (sel_addr),
    .sel_hi      (sel_hi),
    .win_id      (win_id),
    .win_cmd     (win_cmd),
    .win_addr    (win_addr),
    .win_hi      (win_hi),
    .grant       (grant),
    .cycle_cnt   (cycle_cnt),
    .last_ptr    (last_ptr),
    .act_cmd     (act_cmd),
    .act_addr    (act_addr)
  );
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk
  import bus_arb_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 32,
  localparam int NAG   = NPROC + 1,
  localparam int ID_W  = $clog2(NPROC + 2),
  localparam int PTR_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      phase_start,
  input logic                      phase_sel,
  input logic [NPROC*CMD_W-1:0]    proc_cmd,
  input logic [NPROC-1:0]          proc_hi,
  input logic [ID_W-1:0]           win_id,
  input logic [CMD_W-1:0]          win_cmd,
  input logic [ADDR_W-1:0]         win_addr,
  input logic                      win_hi,
  input logic [NAG-1:0]            grant,
  input logic [CYC_W-1:0]          cycle_cnt,
  input logic [PTR_W-1:0]          last_ptr,
  input logic                      mem_req
);
  int  hi_cnt;
  logic any_proc;

  always_comb begin
    hi_cnt   = 0;
    any_proc = 1'b0;
    for (int i = 0; i < NPROC; i++) begin
      if (proc_cmd[i*CMD_W +: CMD_W] != CMD_NONE) begin
        any_proc = 1'b1;
        if (proc_hi[i]) hi_cnt = hi_cnt + 1;
      end
    end
  end

  // R5
  single_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_start |-> hi_cnt <= 1);

  // R5
  hi_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && hi_cnt == 1) |=> win_hi);

  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_start |=> grant == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_start |=> ($stable(win_id) && $stable(win_cmd) && $stable(win_addr) && $stable(win_hi)));

  // R2
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id == '1) |-> (win_cmd == CMD_NONE && win_addr == '0 && !win_hi && grant == '0));

  // R3
  cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && !phase_sel) |=> cycle_cnt == $past(cycle_cnt) + CYC_W'(1));

  // R3
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_start && !phase_sel) |=> $stable(cycle_cnt));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_start && !phase_sel) |=> $stable(last_ptr));

  // R9
  mem_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && phase_sel && mem_req && !any_proc) |=> (win_id == ID_W'(NPROC) && win_cmd == CMD_RPLY));
endmodule

bind bus_arb_top bus_arb_chk #(.NPROC(NPROC), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase_start (phase_start),
  .phase_sel   (phase_sel),
  .proc_cmd    (proc_cmd),
  .proc_hi     (proc_hi),
  .win_id      (win_id),
  .win_cmd     (win_cmd),
  .win_addr    (win_addr),
  .win_hi      (win_hi),
  .grant       (grant),
  .cycle_cnt   (cycle_cnt),
  .last_ptr    (last_ptr),
  .mem_req     (mem_req)
);

// File: tb/sim_bus_arb_top.sv
module sim_bus_arb_top;
  localparam int NP   = 4;
  localparam int AW   = 16;
  localparam int CW   = 32;
  localparam int IDW  = 3;
  localparam int NV   = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            phase_start = 1'b0;
  logic            phase_sel = 1'b0;
  logic [NP*3-1:0] proc_cmd = '0;
  logic [NP*AW-1:0] proc_addr = '0;
  logic [NP-1:0]   proc_hi = '0;
  logic [IDW-1:0]  win_id;
  logic [2:0]      win_cmd;
  logic [AW-1:0]   win_addr;
  logic            win_hi;
  logic [NP:0]     grant;
  logic [CW-1:0]   cycle_cnt;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bus_arb_top #(.NPROC(NP), .ADDR_W(AW), .CYC_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_start(phase_start), .phase_sel(phase_sel),
    .proc_cmd(proc_cmd), .proc_addr(proc_addr), .proc_hi(proc_hi),
    .win_id(win_id), .win_cmd(win_cmd), .win_addr(win_addr), .win_hi(win_hi),
    .grant(grant), .cycle_cnt(cycle_cnt)
  );

  // {phase, cmd3, cmd2, cmd1, cmd0, hi[3:0], exp_id, exp_cmd, exp_hi}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 3'd7, 3'd0, 1'b0}, // idle action
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 3'd7, 3'd0, 1'b0}, // no memory after idle
    {1'b0, 3'd0, 3'd2, 3'd0, 3'd1, 4'b0000, 3'd0, 3'd1, 1'b0}, // R7 first contest
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 3'd4, 3'd4, 1'b0}, // R9 memory reply
    {1'b0, 3'd1, 3'd2, 3'd1, 3'd0, 4'b0000, 3'd1, 3'd1, 1'b0}, // R6 rotation
    {1'b1, 3'd4, 3'd0, 3'd0, 3'd0, 4'b1000, 3'd3, 3'd4, 1'b1}, // R5 beats memory
    {1'b0, 3'd5, 3'd2, 3'd0, 3'd2, 4'b0000, 3'd2, 3'd2, 1'b0}, // R6 R8
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd5, 4'b0000, 3'd0, 3'd5, 1'b0}, // R9 processor beats memory
    {1'b0, 3'd0, 3'd0, 3'd1, 3'd1, 4'b0000, 3'd0, 3'd1, 1'b0}, // R8 pointer kept at 2
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0010, 3'd4, 3'd4, 1'b0}, // R4 null with hi bit
    {1'b0, 3'd3, 3'd0, 3'd1, 3'd0, 4'b1000, 3'd3, 3'd3, 1'b1}, // R5 in action
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 3'd7, 3'd0, 1'b0}, // R9 no reply for upgrade
    {1'b0, 3'd1, 3'd0, 3'd0, 3'd1, 4'b0000, 3'd0, 3'd1, 1'b0}, // R6 wrap after 3
    {1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000, 3'd4, 3'd4, 1'b0}  // R9
  };

  function automatic logic [AW-1:0] addr_of(input int agent, input int idx);
    return AW'((agent + 1) * 256 + idx);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_phase(input bit ph, input logic [11:0] cmds, input logic [3:0] hi, input int idx);
    @(negedge clk);
    phase_start = 1'b1;
    phase_sel   = ph;
    proc_cmd    = cmds;
    proc_hi     = hi;
    for (int i = 0; i < NP; i++) proc_addr[i*AW +: AW] = addr_of(i, idx);
    @(negedge clk);
    phase_start = 1'b0;
    proc_cmd    = '0;
    proc_hi     = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] act_addr_exp;
    int actions;
    act_addr_exp = '0;
    actions = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(win_id == 3'd7, "R1 win_id", 64'(win_id), 64'd7);
    chk(win_cmd == 3'd0 && win_addr == '0 && !win_hi, "R1 win fields", 64'({win_cmd, win_addr, win_hi}), 64'd0);
    chk(grant == '0 && cycle_cnt == '0, "R1 grant/count", 64'({grant, cycle_cnt}), 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [23:0] e;
      logic [2:0]  eid;
      logic [AW-1:0] eaddr;
      logic [NP:0] egnt;
      e   = VEC[v];
      eid = e[6:4];
      do_phase(e[23], e[22:11], e[10:7], v);
      if (eid == 3'd7) eaddr = '0;
      else if (eid == 3'(NP)) eaddr = act_addr_exp;
      else eaddr = addr_of(int'(eid), v);
      if (!e[23]) begin
        actions++;
        act_addr_exp = eaddr;
      end
      egnt = (eid == 3'd7) ? '0 : ((NP+1)'(1) << eid);
      chk(win_id == eid, "R2 R4 R5 R6 R7 R8 R9 winner id", 64'(win_id), 64'(eid));
      chk(win_cmd == e[3:1], "R2 R9 winner cmd", 64'(win_cmd), 64'(e[3:1]));
      chk(win_addr == eaddr, "R2 R9 winner addr", 64'(win_addr), 64'(eaddr));
      chk(win_hi == e[0], "R5 winner priority", 64'(win_hi), 64'(e[0]));
      chk(grant == egnt, "R10 grant pulse", 64'(grant), 64'(egnt));
      chk(cycle_cnt == CW'(actions), "R3 cycle count", 64'(cycle_cnt), 64'(actions));
      @(negedge clk);
      chk(grant == '0, "R10 grant clears", 64'(grant), 64'd0);
    end

    // R2 outputs hold while inputs move without a phase start
    proc_cmd = 12'hFFF;
    proc_hi  = 4'hF;
    repeat (3) @(negedge clk);
    chk(win_id == 3'd4 && win_cmd == 3'd4, "R2 hold id/cmd", 64'({win_id, win_cmd}), 64'h24);
    chk(win_addr == addr_of(0, 12), "R2 hold addr", 64'(win_addr), 64'(addr_of(0, 12)));
    chk(cycle_cnt == CW'(7), "R3 no count without phase", 64'(cycle_cnt), 64'd7);
    proc_cmd = '0;
    proc_hi  = '0;

    // R7 pointer restored by reset: all four contend, processor 0 wins
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_phase(1'b0, {3'd1, 3'd1, 3'd1, 3'd1}, 4'b0000, 20);
    chk(win_id == 3'd0, "R7 agent 0 first after reset", 64'(win_id), 64'd0);
    chk(cycle_cnt == CW'(1), "R3 count after reset", 64'(cycle_cnt), 64'd1);
    // R6 then R8: next contest from pointer 0 goes to 1
    do_phase(1'b1, {3'd0, 3'd0, 3'd0, 3'd0}, 4'b0000, 21);
    chk(win_id == 3'd4, "R9 memory after read", 64'(win_id), 64'd4);
    do_phase(1'b0, {3'd1, 3'd1, 3'd1, 3'd1}, 4'b0000, 22);
    chk(win_id == 3'd1, "R6 R8 rotation after reset", 64'(win_id), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule